// File: doc/BRIEF.md
# Peripheral DMA channel controller

This block moves words between system memory and one serial peripheral without processor involvement. It has two independent directions, receive and transmit. Each direction holds a current buffer (pointer and word count) and a queued next buffer. When the current buffer runs out, the queued one takes its place in the same cycle, so the peripheral sees a gapless stream across two buffers.

Software programs the eight buffer registers and one control register through a 32-bit register write and read port. Toward memory, each direction raises a request with a word address and waits for an acknowledge. Each acknowledged word advances the pointer by the word size and uses up one count. Toward the peripheral's status unit, the block gives a one-cycle end-of-buffer pulse and three level flags per direction: end-of-buffer, both-buffers-exhausted, and final-buffer. Interrupt masking is done downstream.

Top module: `periph_dma_ctrl`

## Requirements
- R1: After reset, every pointer, counter and enable reads zero, and no request is raised. Both end-of-buffer flags and both exhausted flags are 1. The final-buffer flags and the end pulses are 0.
- R2: A write to control address 0x20 handles each direction on its own. Bit 0 turns receive on and bit 1 turns it off. Bit 8 turns transmit on and bit 9 turns it off. When both bits for one direction are written together, the direction ends up off. Reading 0x20 returns the receive enable in bit 0 and the transmit enable in bit 8.
- R3: Each buffer register can be written and read back at its own byte address. Receive uses 0x00 current pointer, 0x04 current count, 0x08 next pointer and 0x0C next count. Transmit uses the same layout at 0x10 to 0x1C. Counts are 16 bits wide.
- R4: A direction requests only while it is enabled and its current count is non-zero. The request address equals the current pointer. Each acknowledged request adds 4 to the pointer and subtracts 1 from the count. A disabled direction keeps its pointer and count no matter what the acknowledge does.
- R5: When an acknowledged word takes the current count from 1 to 0, the direction's end pulse is high for exactly the next cycle and its end-of-buffer flag becomes 1. Writing zero to a counter raises neither.
- R6: While a direction is enabled, its current count is zero and its next count is non-zero, the current pointer and count load from the next registers on the following edge, and the next count becomes zero. The words therefore continue at the next pointer without a gap.
- R7: The receive-full flag, and likewise the transmit-empty flag, is 1 exactly when both of that direction's counts are zero.
- R8: A non-zero write to a current count clears that direction's end-of-buffer flag, and the exhausted flag then reads 0. A non-zero write to a next count clears only the exhausted flag.
- R9: When a direction is turned on, its final-buffer flag is set to 1 if the next count is zero at that moment, and to 0 otherwise. The flag becomes 1 when the next buffer is loaded and becomes 0 when the direction is turned off.
- R10: The two directions are independent: traffic, acknowledges and register writes on one never change the other's request, pointer, count or flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte address for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| rx_req | output | 1 | Receive word request to memory |
| rx_addr | output | AW | Receive word address |
| rx_ack | input | 1 | Receive word accepted |
| tx_req | output | 1 | Transmit word request to memory |
| tx_addr | output | AW | Transmit word address |
| tx_ack | input | 1 | Transmit word accepted |
| rx_end_pulse | output | 1 | One-cycle pulse when a receive buffer completes |
| rx_end | output | 1 | Receive end-of-buffer level flag |
| rx_full | output | 1 | Both receive counts are zero |
| rx_last | output | 1 | Receive is working on its final buffer |
| tx_end_pulse | output | 1 | One-cycle pulse when a transmit buffer completes |
| tx_end | output | 1 | Transmit end-of-buffer level flag |
| tx_empty | output | 1 | Both transmit counts are zero |
| tx_last | output | 1 | Transmit is working on its final buffer |

## Verification
A register write shows its effect one edge after the strobe, and the request and address follow on the same edge because they are combinational from the registers. An acknowledge advances the pointer on the edge that samples it, and the end pulse and end flag appear on that same edge. A chained reload happens on the edge after the count reaches zero only if the count reaches zero without an acknowledge; after a final acknowledge the reload happens on that acknowledge's own edge. The bench drives every input on a falling edge and reads outputs on the next falling edge, so each result is read exactly one edge after its cause. It matches every acknowledged address against an expected address sequence that it computes itself.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  localparam int NUM_CH      = 2;
  localparam int CH_RX       = 0;
  localparam int CH_TX       = 1;
  localparam int REG_AW      = 6;
  localparam int CH_SEL_BIT  = 4;
  localparam int CTL_SEL_BIT = 5;
  localparam int CTL_STRIDE  = 8;

  typedef enum logic [1:0] {
    F_PTR  = 2'd0,
    F_CNT  = 2'd1,
    F_NPTR = 2'd2,
    F_NCNT = 2'd3
  } fld_e;

  typedef struct packed {
    logic ptr;
    logic cnt;
    logic nptr;
    logic ncnt;
    logic on;
    logic off;
  } chan_wr_t;
endpackage

// File: rtl/pdc_decode.sv
module pdc_decode
  import pdc_pkg::*;
(
  input  logic                    wr_en_i,
  input  logic [REG_AW-1:0]       addr_i,
  input  logic [NUM_CH-1:0]       on_bits_i,
  input  logic [NUM_CH-1:0]       off_bits_i,
  output chan_wr_t [NUM_CH-1:0]   wr_o
);
  logic aligned;
  logic reg_hit;
  logic ctl_hit;
  fld_e fld;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign reg_hit = wr_en_i && aligned && !addr_i[CTL_SEL_BIT];
  assign ctl_hit = wr_en_i && aligned && addr_i[CTL_SEL_BIT] &&
                   (addr_i[CTL_SEL_BIT-1:2] == '0);
  assign fld     = fld_e'(addr_i[3:2]);

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic mine;
      assign mine    = reg_hit && (addr_i[CH_SEL_BIT] == 1'(c));
      assign wr_o[c] = '{ptr:  mine && (fld == F_PTR),
                         cnt:  mine && (fld == F_CNT),
                         nptr: mine && (fld == F_NPTR),
                         ncnt: mine && (fld == F_NCNT),
                         on:   ctl_hit && on_bits_i[c],
                         off:  ctl_hit && off_bits_i[c]};
    end
  endgenerate
endmodule

// File: rtl/pdc_chan.sv
module pdc_chan
  import pdc_pkg::*;
#(
  parameter int AW         = 32,
  parameter int CW         = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  chan_wr_t      wr_i,
  input  logic [AW-1:0] wptr_i,
  input  logic [CW-1:0] wcnt_i,
  input  logic          ack_i,
  output logic          req_o,
  output logic [AW-1:0] maddr_o,
  output logic          end_pulse_o,
  output logic          end_flag_o,
  output logic          drained_o,
  output logic          last_o,
  output logic          en_o,
  output logic [AW-1:0] ptr_o,
  output logic [AW-1:0] nptr_o,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] ncnt_o
);
  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [AW-1:0] ptr_q, ptr_d, nptr_q, nptr_d;
  logic [CW-1:0] cnt_q, cnt_d, ncnt_q, ncnt_d, cnt_after;
  logic          en_q, en_d, end_q, end_d, pulse_q, pulse_d, last_q, last_d;
  logic          xfer, hit_zero, reload, wcnt_nz, any_wr;
  logic          ptr_ce, cnt_ce, nptr_ce, ncnt_ce, flag_ce;

  assign req_o     = en_q && (cnt_q != '0);
  assign xfer      = req_o && ack_i;
  assign hit_zero  = xfer && (cnt_q == ONE);
  assign cnt_after = xfer ? (cnt_q - ONE) : cnt_q;
  assign reload    = en_q && (cnt_after == '0) && (ncnt_q != '0);
  assign wcnt_nz   = (wcnt_i != '0);
  assign any_wr    = wr_i.ptr || wr_i.cnt || wr_i.nptr || wr_i.ncnt;

  // next-state logic
  always_comb begin
    ptr_d  = ptr_q;
    cnt_d  = cnt_after;
    nptr_d = nptr_q;
    ncnt_d = ncnt_q;
    if (reload) begin
      ptr_d  = nptr_q;
      cnt_d  = ncnt_q;
      ncnt_d = '0;
    end else if (xfer) begin
      ptr_d = ptr_q + STEP;
    end
    if (wr_i.ptr)  ptr_d  = wptr_i;
    if (wr_i.cnt)  cnt_d  = wcnt_i;
    if (wr_i.nptr) nptr_d = wptr_i;
    if (wr_i.ncnt) ncnt_d = wcnt_i;
  end

  always_comb begin
    en_d = en_q;
    if (wr_i.on)  en_d = 1'b1;
    if (wr_i.off) en_d = 1'b0;

    end_d = end_q;
    if (hit_zero)             end_d = 1'b1;
    if (wr_i.cnt && wcnt_nz)  end_d = 1'b0;

    pulse_d = hit_zero;

    last_d = last_q;
    if (reload)               last_d = 1'b1;
    if (wr_i.ncnt && wcnt_nz) last_d = 1'b0;
    if (wr_i.on)              last_d = (ncnt_q == '0);
    if (wr_i.off)             last_d = 1'b0;
  end

  assign ptr_ce  = xfer || reload || wr_i.ptr;
  assign cnt_ce  = xfer || reload || wr_i.cnt;
  assign nptr_ce = wr_i.nptr;
  assign ncnt_ce = reload || wr_i.ncnt;
  assign flag_ce = hit_zero || reload || wr_i.cnt || wr_i.ncnt || wr_i.on || wr_i.off;

  // state registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      cnt_q   <= '0;
      nptr_q  <= '0;
      ncnt_q  <= '0;
      en_q    <= 1'b0;
      end_q   <= 1'b1;
      pulse_q <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      if (ptr_ce)  ptr_q  <= ptr_d;
      if (cnt_ce)  cnt_q  <= cnt_d;
      if (nptr_ce) nptr_q <= nptr_d;
      if (ncnt_ce) ncnt_q <= ncnt_d;
      if (flag_ce) begin
        en_q   <= en_d;
        end_q  <= end_d;
        last_q <= last_d;
      end
      pulse_q <= pulse_d;
    end
  end

  assign maddr_o     = ptr_q;
  assign end_pulse_o = pulse_q;
  assign end_flag_o  = end_q;
  assign drained_o   = (cnt_q == '0) && (ncnt_q == '0);
  assign last_o      = last_q;
  assign en_o        = en_q;
  assign ptr_o       = ptr_q;
  assign nptr_o      = nptr_q;
  assign cnt_o       = cnt_q;
  assign ncnt_o      = ncnt_q;

  // R2: disable applied after enable
  a_r2_off_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i.on && wr_i.off) |=> !en_q);

  // R4: one word step per acknowledge
  a_r4_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && ack_i && (cnt_q != ONE) && !any_wr)
      |=> (ptr_q == $past(ptr_q) + STEP) && (cnt_q == $past(cnt_q) - ONE));

  // R4: nothing moves while disabled
  a_r4_hold_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !any_wr && !wr_i.on) |=> $stable(ptr_q) && $stable(cnt_q));

  // R5: pulse only follows a final acknowledge
  a_r5_pulse_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |-> $past(req_o && ack_i && (cnt_q == ONE)));

  // R6: chained buffer load on completion
  a_r6_chain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && ack_i && (cnt_q == ONE) && (ncnt_q != '0) && !any_wr)
      |=> (cnt_q == $past(ncnt_q)) && (ptr_q == $past(nptr_q)) && (ncnt_q == '0));

  // R8: non-zero current count write clears end flag
  a_r8_end_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i.cnt && (wcnt_i != '0)) |=> !end_q);
endmodule

// File: rtl/periph_dma_ctrl.sv
module periph_dma_ctrl
  import pdc_pkg::*;
#(
  parameter int AW         = 32,
  parameter int CW         = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              rx_req,
  output logic [AW-1:0]     rx_addr,
  input  logic              rx_ack,
  output logic              tx_req,
  output logic [AW-1:0]     tx_addr,
  input  logic              tx_ack,
  output logic              rx_end_pulse,
  output logic              rx_end,
  output logic              rx_full,
  output logic              rx_last,
  output logic              tx_end_pulse,
  output logic              tx_end,
  output logic              tx_empty,
  output logic              tx_last
);
  logic [1:0] rst_sync_q;
  logic       rst_ns;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  chan_wr_t [NUM_CH-1:0] wr;
  logic [NUM_CH-1:0]     on_bits, off_bits;
  logic [NUM_CH-1:0]     ack, req, pulse, endf, drained, last, en;
  logic [AW-1:0]         maddr [NUM_CH];
  logic [AW-1:0]         ptr_a [NUM_CH];
  logic [AW-1:0]         nptr_a[NUM_CH];
  logic [CW-1:0]         cnt_a [NUM_CH];
  logic [CW-1:0]         ncnt_a[NUM_CH];

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_bits
      assign on_bits[c]  = reg_wdata[c*CTL_STRIDE];
      assign off_bits[c] = reg_wdata[c*CTL_STRIDE+1];
    end
  endgenerate

  pdc_decode u_dec (
    .wr_en_i    (reg_wr),
    .addr_i     (reg_addr),
    .on_bits_i  (on_bits),
    .off_bits_i (off_bits),
    .wr_o       (wr)
  );

  assign ack[CH_RX] = rx_ack;
  assign ack[CH_TX] = tx_ack;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      pdc_chan #(.AW(AW), .CW(CW), .WORD_BYTES(WORD_BYTES)) u_chan (
        .clk_i       (clk),
        .rst_ni      (rst_ns),
        .wr_i        (wr[c]),
        .wptr_i      (reg_wdata[AW-1:0]),
        .wcnt_i      (reg_wdata[CW-1:0]),
        .ack_i       (ack[c]),
        .req_o       (req[c]),
        .maddr_o     (maddr[c]),
        .end_pulse_o (pulse[c]),
        .end_flag_o  (endf[c]),
        .drained_o   (drained[c]),
        .last_o      (last[c]),
        .en_o        (en[c]),
        .ptr_o       (ptr_a[c]),
        .nptr_o      (nptr_a[c]),
        .cnt_o       (cnt_a[c]),
        .ncnt_o      (ncnt_a[c])
      );
    end
  endgenerate

  // register read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_addr[1:0] == 2'b00) begin
      if (reg_addr[CTL_SEL_BIT]) begin
        if (reg_addr[CTL_SEL_BIT-1:2] == '0) begin
          for (int c = 0; c < NUM_CH; c++) reg_rdata[c*CTL_STRIDE] = en[c];
        end
      end else begin
        case (fld_e'(reg_addr[3:2]))
          F_PTR:   reg_rdata = 32'(ptr_a [reg_addr[CH_SEL_BIT]]);
          F_CNT:   reg_rdata = 32'(cnt_a [reg_addr[CH_SEL_BIT]]);
          F_NPTR:  reg_rdata = 32'(nptr_a[reg_addr[CH_SEL_BIT]]);
          default: reg_rdata = 32'(ncnt_a[reg_addr[CH_SEL_BIT]]);
        endcase
      end
    end
  end

  assign rx_req       = req[CH_RX];
  assign rx_addr      = maddr[CH_RX];
  assign tx_req       = req[CH_TX];
  assign tx_addr      = maddr[CH_TX];
  assign rx_end_pulse = pulse[CH_RX];
  assign rx_end       = endf[CH_RX];
  assign rx_full      = drained[CH_RX];
  assign rx_last      = last[CH_RX];
  assign tx_end_pulse = pulse[CH_TX];
  assign tx_end       = endf[CH_TX];
  assign tx_empty     = drained[CH_TX];
  assign tx_last      = last[CH_TX];

  // R10: receive writes never touch transmit enable
  a_r10_indep: assert property (@(posedge clk) disable iff (!rst_ns)
    (!wr[CH_TX].on && !wr[CH_TX].off) |=> $stable(en[CH_TX]));
endmodule

// File: tb/periph_dma_ctrl_test.sv
`timescale 1ns/1ps
module periph_dma_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [5:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        rx_req, tx_req, rx_end_pulse, tx_end_pulse;
  logic [31:0] rx_addr, tx_addr;
  logic        rx_end, rx_full, rx_last, tx_end, tx_empty, tx_last;
  logic [1:0]  ack_v;

  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  periph_dma_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_req(rx_req), .rx_addr(rx_addr), .rx_ack(ack_v[0]),
    .tx_req(tx_req), .tx_addr(tx_addr), .tx_ack(ack_v[1]),
    .rx_end_pulse(rx_end_pulse), .rx_end(rx_end), .rx_full(rx_full), .rx_last(rx_last),
    .tx_end_pulse(tx_end_pulse), .tx_end(tx_end), .tx_empty(tx_empty), .tx_last(tx_last)
  );

  logic [1:0]  req_v, pulse_v, end_v, full_v, last_v;
  logic [31:0] addr_v [2];
  assign req_v   = {tx_req, rx_req};
  assign pulse_v = {tx_end_pulse, rx_end_pulse};
  assign end_v   = {tx_end, rx_end};
  assign full_v  = {tx_empty, rx_full};
  assign last_v  = {tx_last, rx_last};
  assign addr_v[0] = rx_addr;
  assign addr_v[1] = tx_addr;

  localparam logic [5:0] A_CTL = 6'h20;

  function automatic logic [5:0] reg_a(input int ch, input int fld);
    return 6'(ch * 16 + fld * 4);
  endfunction

  function automatic logic [31:0] exp_addr(input logic [31:0] b1, input int n1,
                                           input logic [31:0] b2, input int idx);
    if (idx < n1) return b1 + 32'(4 * idx);
    return b2 + 32'(4 * (idx - n1));
  endfunction

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic run(input int na [2], input int nb [2],
                     input logic [31:0] ba [2], input logic [31:0] bb [2]);
    int idx [2];
    int tot [2];
    int pulses [2];
    int guard;
    logic [31:0] ctl;
    logic [31:0] v;
    ctl = '0;
    for (int c = 0; c < 2; c++) begin
      idx[c] = 0; pulses[c] = 0; tot[c] = na[c] + nb[c];
      if (tot[c] > 0) begin
        wr(reg_a(c, 0), ba[c]);
        wr(reg_a(c, 1), 32'(na[c]));
        wr(reg_a(c, 2), bb[c]);
        wr(reg_a(c, 3), 32'(nb[c]));
        if (na[c] > 0) chk(end_v[c] == 1'b0, "R8 end cleared by count write", 32'(end_v[c]), 0);
        chk(full_v[c] == 1'b0, "R7 flag low with data", 32'(full_v[c]), 0);
        ctl = ctl | (32'h1 << (8 * c));
      end
    end
    if (ctl != 0) wr(A_CTL, ctl);
    for (int c = 0; c < 2; c++)
      if (na[c] > 0)
        chk(last_v[c] == (nb[c] == 0), "R9 final-buffer at enable", 32'(last_v[c]), 32'(nb[c] == 0));
    guard = 0;
    while ((idx[0] < tot[0] || idx[1] < tot[1]) && guard < 4000) begin
      @(negedge clk);
      guard++;
      for (int c = 0; c < 2; c++) begin
        pulses[c] += int'(pulse_v[c]);
        if (req_v[c] && idx[c] >= tot[c]) chk(1'b0, "R4 request beyond count", 32'(idx[c]), 32'(tot[c]));
        ack_v[c] = 1'($urandom_range(0, 1));
        if (req_v[c] && ack_v[c]) begin
          v = exp_addr(ba[c], na[c], bb[c], idx[c]);
          chk(addr_v[c] == v, (c == 0) ? "R6 rx address sequence" : "R6 tx address sequence", addr_v[c], v);
          idx[c]++;
        end
      end
    end
    chk(guard < 4000, "R4 transfers completed", 32'(guard), 0);
    @(negedge clk);
    for (int c = 0; c < 2; c++) pulses[c] += int'(pulse_v[c]);
    ack_v = 2'b00;
    repeat (2) begin
      @(negedge clk);
      for (int c = 0; c < 2; c++) pulses[c] += int'(pulse_v[c]);
    end
    for (int c = 0; c < 2; c++) begin
      if (tot[c] > 0) begin
        chk(pulses[c] == int'(na[c] > 0) + int'(nb[c] > 0), "R5 end pulse count",
            32'(pulses[c]), 32'(int'(na[c] > 0) + int'(nb[c] > 0)));
        chk(end_v[c] == 1'b1, "R5 end flag set", 32'(end_v[c]), 1);
        chk(full_v[c] == 1'b1, "R7 both counts zero", 32'(full_v[c]), 1);
        chk(req_v[c] == 1'b0, "R4 no request at zero", 32'(req_v[c]), 0);
        chk(last_v[c] == 1'b1, "R9 final buffer after chain", 32'(last_v[c]), 1);
        rd(reg_a(c, 0), v);
        chk(v == exp_addr(ba[c], na[c], bb[c], tot[c] - 1) + 32'd4, "R4 final pointer",
            v, exp_addr(ba[c], na[c], bb[c], tot[c] - 1) + 32'd4);
      end else begin
        chk(pulses[c] == 0, "R10 idle direction silent", 32'(pulses[c]), 0);
      end
    end
    if (ctl != 0) wr(A_CTL, ctl << 1);
  endtask

  initial begin
    #(5.0 * 150000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int na [2];
    int nb [2];
    logic [31:0] ba [2];
    logic [31:0] bb [2];
    void'($urandom(32'd20240611));
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; ack_v = 2'b00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(req_v == 2'b00, "R1 no request", 32'(req_v), 0);
    chk(end_v == 2'b11, "R1 end flags", 32'(end_v), 3);
    chk(full_v == 2'b11, "R1 exhausted flags", 32'(full_v), 3);
    chk(last_v == 2'b00, "R1 final-buffer flags", 32'(last_v), 0);
    chk(pulse_v == 2'b00, "R1 no pulse", 32'(pulse_v), 0);
    for (int c = 0; c < 2; c++)
      for (int f = 0; f < 4; f++) begin
        rd(reg_a(c, f), v);
        chk(v == 0, "R1 register zero", v, 0);
      end
    rd(A_CTL, v);
    chk(v == 0, "R1 enables zero", v, 0);

    // R3 readback of every buffer register
    for (int c = 0; c < 2; c++)
      for (int f = 0; f < 4; f++) begin
        v = 32'hA5C3_0000 + 32'(c * 64 + f * 4 + 4);
        wr(reg_a(c, f), v);
      end
    for (int c = 0; c < 2; c++)
      for (int f = 0; f < 4; f++) begin
        logic [31:0] e;
        e = 32'hA5C3_0000 + 32'(c * 64 + f * 4 + 4);
        if (f % 2 == 1) e = e & 32'h0000_FFFF;
        rd(reg_a(c, f), v);
        chk(v == e, "R3 register readback", v, e);
      end
    chk(end_v == 2'b00, "R8 end flags cleared by writes", 32'(end_v), 0);
    // R8 zero write leaves end flag clear, next count write clears exhausted only
    wr(reg_a(0, 1), 0);
    wr(reg_a(0, 3), 0);
    chk(rx_full == 1'b1, "R7 rx full when both zero", 32'(rx_full), 1);
    chk(rx_end == 1'b0, "R5 zero write raises no end flag", 32'(rx_end), 0);
    chk(rx_end_pulse == 1'b0, "R5 zero write raises no pulse", 32'(rx_end_pulse), 0);
    chk(tx_empty == 1'b0, "R10 tx flag untouched by rx writes", 32'(tx_empty), 0);
    wr(reg_a(1, 1), 0);
    wr(reg_a(1, 3), 0);
    chk(tx_empty == 1'b1, "R7 tx empty when both zero", 32'(tx_empty), 1);

    // R2 control bits
    wr(A_CTL, 32'h0000_0003);
    rd(A_CTL, v);
    chk(v == 0, "R2 rx on+off ends off", v, 0);
    wr(A_CTL, 32'h0000_0001);
    rd(A_CTL, v);
    chk(v == 32'h1, "R2 rx on", v, 32'h1);
    wr(A_CTL, 32'h0000_0100);
    rd(A_CTL, v);
    chk(v == 32'h101, "R2 tx on keeps rx", v, 32'h101);
    wr(A_CTL, 32'h0000_0300);
    rd(A_CTL, v);
    chk(v == 32'h1, "R2 tx on+off ends off", v, 32'h1);
    wr(A_CTL, 32'h0000_0002);
    rd(A_CTL, v);
    chk(v == 0, "R2 rx off", v, 0);

    // R9 final-buffer flag at enable
    wr(reg_a(0, 1), 2);
    wr(reg_a(0, 3), 3);
    chk(rx_full == 1'b0, "R8 next count clears full", 32'(rx_full), 0);
    wr(A_CTL, 32'h1);
    chk(rx_last == 1'b0, "R9 not final with next queued", 32'(rx_last), 0);
    wr(A_CTL, 32'h2);
    wr(reg_a(0, 3), 0);
    wr(A_CTL, 32'h1);
    chk(rx_last == 1'b1, "R9 final with next empty", 32'(rx_last), 1);
    wr(A_CTL, 32'h2);
    chk(rx_last == 1'b0, "R9 cleared on disable", 32'(rx_last), 0);
    wr(reg_a(0, 1), 0);

    // R4 disable mid-buffer holds state
    wr(reg_a(0, 0), 32'h0000_1000);
    wr(reg_a(0, 1), 4);
    wr(A_CTL, 32'h1);
    chk(rx_req == 1'b1 && rx_addr == 32'h1000, "R4 request at pointer", rx_addr, 32'h1000);
    chk(tx_req == 1'b0, "R10 tx idle", 32'(tx_req), 0);
    ack_v[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(rx_addr == 32'h1008, "R4 pointer advanced by 4 per word", rx_addr, 32'h1008);
    ack_v[0] = 1'b0;
    wr(A_CTL, 32'h2);
    ack_v[0] = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(rx_req == 1'b0, "R4 no request when disabled", 32'(rx_req), 0);
    end
    ack_v[0] = 1'b0;
    rd(reg_a(0, 1), v);
    chk(v == 2, "R4 count held when disabled", v, 2);
    rd(reg_a(0, 0), v);
    chk(v == 32'h1008, "R4 pointer held when disabled", v, 32'h1008);
    wr(reg_a(0, 1), 0);

    // directed chained and single-buffer runs
    na = '{3, 0}; nb = '{2, 0}; ba = '{32'h2000, 0}; bb = '{32'h3000, 0};
    run(na, nb, ba, bb);
    na = '{0, 1}; nb = '{0, 0}; ba = '{0, 32'h4000}; bb = '{0, 32'h5000};
    run(na, nb, ba, bb);
    na = '{0, 0}; nb = '{4, 0}; ba = '{32'h6000, 0}; bb = '{32'h7000, 0};
    run(na, nb, ba, bb);
    na = '{1, 1}; nb = '{1, 1}; ba = '{32'hFFFF_FFFC, 32'h8000}; bb = '{32'h10, 32'h9000};
    run(na, nb, ba, bb);

    // random concurrent runs
    for (int i = 0; i < 8; i++) begin
      for (int c = 0; c < 2; c++) begin
        na[c] = int'($urandom_range(0, 6));
        nb[c] = int'($urandom_range(0, 6));
        ba[c] = $urandom & 32'hFFFF_FFFC;
        bb[c] = $urandom & 32'hFFFF_FFFC;
      end
      run(na, nb, ba, bb);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule